// File: doc/BRIEF.md
# Three-Phase Bridge Gate Gating Logic

This block turns a commutation step number into the six gate enables of a three-phase bridge: three high-side drivers (active low) and three low-side drivers (active high). Each of the six valid steps turns on one high-side switch and one low-side switch on two different phases and leaves the third phase floating. A direction bit walks the step table in the opposite order.

Four overrides sit on top of the step pattern. Listed from strongest to weakest, they are:
- an undervoltage shutdown, which also drives an active-low fault output;
- an active-low brake, which shorts the windings through the low side;
- a current-limit blanking window, which holds the low side off for a programmed number of cycles after a trip pulse;
- a PWM gate, which chops only the active low-side switch.

A per-leg guard keeps the two switches of a leg from conducting together. It also inserts a programmable dead time before a switch turns on after its complementary switch on the same leg.

All outputs are registered. A change on any input appears at the outputs one rising edge later, unless the dead-time guard holds a switch back for longer.

Top module: `bldc_gate_drive`

## Requirements
- R1: During and after synchronous reset, with no request applied, the outputs are `hs_n = 3'b111`, `ls = 3'b000` and `fault_n = 1`.
- R2: With `dir_rev = 0`, a step `k` in 0..5 maps to one high-side phase and one low-side phase (bit 0 = phase A, bit 1 = B, bit 2 = C). The mapping is: 0 → A high, B low; 1 → A high, C low; 2 → B high, C low; 3 → B high, A low; 4 → C high, A low; 5 → C high, B low. The outputs follow one edge after the inputs, subject to dead time.
- R3: With `dir_rev = 1`, step `k` drives the pattern that R2 gives for step `5 - k`.
- R4: Step values 6 and 7 turn every driver off.
- R5: While neither brake nor blanking is active, `pwm_gate` gates only the selected low-side switch. When `pwm_gate = 0` that switch is off, and the selected high-side switch stays on.
- R6: When `brake_n = 0` and undervoltage is absent, all high-side drivers are off and all three low-side drivers are on. Dead time still applies, and braking overrides both blanking and `pwm_gate`.
- R7: `ilim_trip` sampled high at an edge E forces all low-side drivers off at the outputs updated by edges E+1 through E+`BLANK_CYC`. A further trip restarts the window.
- R8: `uv_flag` sampled high turns every driver off and drives `fault_n` low at the next edge. Undervoltage has priority over all other inputs.
- R9: The high-side and low-side switches of the same leg are never on in the same cycle.
- R10: A switch that is requested on after the complementary switch of its leg was on is held off for `DEAD_CYC` cycles, counted from the edge that turned the complementary switch off.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| phase_idx | input | 3 | Commutation step, 0..5 valid |
| dir_rev | input | 1 | 1 walks the step table in reverse |
| brake_n | input | 1 | Active-low brake request |
| ilim_trip | input | 1 | Current-limit trip pulse |
| uv_flag | input | 1 | Undervoltage present |
| pwm_gate | input | 1 | PWM chop for the active low-side switch |
| hs_n | output | 3 | High-side drivers, active low, bit 0 = phase A |
| ls | output | 3 | Low-side drivers, active high, bit 0 = phase A |
| fault_n | output | 1 | Low while undervoltage shutdown is in force |

## Verification
The bench builds the block with `DEAD_CYC = 3` and `BLANK_CYC = 6`. These values keep every dead-time gap and every blanking window short enough that random step changes, trip pulses and brake bursts often land inside one another. That mixing reaches the cases where a trip restarts a running window, where braking begins while a leg is still waiting out its dead time, and where undervoltage cuts into both.

// File: rtl/bldc_gate_pkg.sv
package bldc_gate_pkg;

    localparam int NUM_LEGS  = 3;
    localparam int NUM_STEPS = 6;

    typedef logic [2:0] phase_idx_t;
    typedef logic [NUM_LEGS-1:0] leg_vec_t;

    typedef struct packed {
        leg_vec_t hi;
        leg_vec_t lo;
    } bridge_req_t;

    // Step pattern: one high-side leg and one low-side leg, bit 0 = phase A.
    function automatic bridge_req_t comm_pattern(input phase_idx_t idx, input logic rev);
        bridge_req_t r;
        phase_idx_t  eff;
        r   = '0;
        eff = idx;
        if (idx < phase_idx_t'(NUM_STEPS)) begin
            if (rev) eff = phase_idx_t'(NUM_STEPS - 1) - idx;
            case (eff)
                3'd0: begin r.hi = 3'b001; r.lo = 3'b010; end
                3'd1: begin r.hi = 3'b001; r.lo = 3'b100; end
                3'd2: begin r.hi = 3'b010; r.lo = 3'b100; end
                3'd3: begin r.hi = 3'b010; r.lo = 3'b001; end
                3'd4: begin r.hi = 3'b100; r.lo = 3'b001; end
                3'd5: begin r.hi = 3'b100; r.lo = 3'b010; end
                default: r = '0;
            endcase
        end
        return r;
    endfunction

endpackage

// File: rtl/bldc_comm_decode.sv
module bldc_comm_decode
    import bldc_gate_pkg::*;
(
    input  phase_idx_t  phase_idx,
    input  logic        dir_rev,
    input  logic        brake_n,
    input  logic        uv_flag,
    input  logic        blank_active,
    input  logic        pwm_gate,
    output bridge_req_t req
);

    bridge_req_t pat;

    always_comb begin
        pat = comm_pattern(phase_idx, dir_rev);
        req = '0;
        if (uv_flag) begin
            req = '0;
        end else if (!brake_n) begin
            req.hi = '0;
            req.lo = '1;
        end else begin
            req.hi = pat.hi;
            req.lo = (blank_active || !pwm_gate) ? '0 : pat.lo;
        end
    end

endmodule

// File: rtl/bldc_ilim_blank.sv
module bldc_ilim_blank #(
    parameter int BLANK_CYC = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic ilim_trip,
    output logic blank_active
);

    localparam int CW = $clog2(BLANK_CYC + 1);
    localparam logic [CW-1:0] LOAD = CW'(BLANK_CYC);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (ilim_trip) begin
            cnt <= LOAD;
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign blank_active = (cnt != '0);

    a_r7_trip_opens_window: assert property (@(posedge clk) disable iff (rst)
        ilim_trip |=> blank_active);

endmodule

// File: rtl/bldc_leg_guard.sv
module bldc_leg_guard #(
    parameter int DEAD_CYC = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic req_hi,
    input  logic req_lo,
    output logic hi_q,
    output logic lo_q
);

    localparam int CW = $clog2(DEAD_CYC + 1);
    localparam logic [CW-1:0] SAT = CW'(DEAD_CYC);
    localparam logic [CW-1:0] THR = CW'(DEAD_CYC - 1);

    logic [CW-1:0] hi_off_cnt;
    logic [CW-1:0] lo_off_cnt;
    logic          hi_ok;
    logic          lo_ok;
    logic          hi_d;
    logic          lo_d;

    always_comb begin
        hi_ok = !lo_q && (lo_off_cnt >= THR);
        lo_ok = !hi_q && (hi_off_cnt >= THR);
        hi_d  = req_hi && !req_lo && (hi_q || hi_ok);
        lo_d  = req_lo && !req_hi && (lo_q || lo_ok);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            hi_q       <= 1'b0;
            lo_q       <= 1'b0;
            hi_off_cnt <= SAT;
            lo_off_cnt <= SAT;
        end else begin
            hi_q       <= hi_d;
            lo_q       <= lo_d;
            hi_off_cnt <= hi_q ? '0 : ((hi_off_cnt == SAT) ? SAT : hi_off_cnt + 1'b1);
            lo_off_cnt <= lo_q ? '0 : ((lo_off_cnt == SAT) ? SAT : lo_off_cnt + 1'b1);
        end
    end

    a_r9_leg_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(hi_q && lo_q));

    a_r10_hi_gap: assert property (@(posedge clk) disable iff (rst)
        $rose(hi_q) |-> !$past(lo_q));

    a_r10_lo_gap: assert property (@(posedge clk) disable iff (rst)
        $rose(lo_q) |-> !$past(hi_q));

endmodule

// File: rtl/bldc_gate_drive.sv
module bldc_gate_drive
    import bldc_gate_pkg::*;
#(
    parameter int DEAD_CYC  = 4,
    parameter int BLANK_CYC = 16
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [2:0] phase_idx,
    input  logic       dir_rev,
    input  logic       brake_n,
    input  logic       ilim_trip,
    input  logic       uv_flag,
    input  logic       pwm_gate,
    output logic [2:0] hs_n,
    output logic [2:0] ls,
    output logic       fault_n
);

    logic        blank_active;
    bridge_req_t req;
    leg_vec_t    hi_on;
    leg_vec_t    lo_on;

    bldc_ilim_blank #(.BLANK_CYC(BLANK_CYC)) u_blank (
        .clk          (clk),
        .rst          (rst),
        .ilim_trip    (ilim_trip),
        .blank_active (blank_active)
    );

    bldc_comm_decode u_decode (
        .phase_idx    (phase_idx),
        .dir_rev      (dir_rev),
        .brake_n      (brake_n),
        .uv_flag      (uv_flag),
        .blank_active (blank_active),
        .pwm_gate     (pwm_gate),
        .req          (req)
    );

    for (genvar g = 0; g < NUM_LEGS; g++) begin : g_leg
        bldc_leg_guard #(.DEAD_CYC(DEAD_CYC)) u_guard (
            .clk    (clk),
            .rst    (rst),
            .req_hi (req.hi[g]),
            .req_lo (req.lo[g]),
            .hi_q   (hi_on[g]),
            .lo_q   (lo_on[g])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) fault_n <= 1'b1;
        else     fault_n <= !uv_flag;
    end

    assign hs_n = ~hi_on;
    assign ls   = lo_on;

    a_r8_uv_shutdown: assert property (@(posedge clk) disable iff (rst)
        uv_flag |=> (hs_n == 3'b111 && ls == 3'b000 && !fault_n));

    a_r6_brake_high_off: assert property (@(posedge clk) disable iff (rst)
        !brake_n |=> (hs_n == 3'b111));

    a_r7_low_blanked: assert property (@(posedge clk) disable iff (rst)
        (blank_active && brake_n) |=> (ls == 3'b000));

    a_r2_single_high: assert property (@(posedge clk) disable iff (rst)
        $onehot0(~hs_n));

endmodule

// File: tb/bldc_gate_drive_tb.sv
module bldc_gate_drive_tb;

    localparam int DEAD  = 3;
    localparam int BLANK = 6;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [2:0] phase_idx = 3'd0;
    logic       dir_rev = 1'b0;
    logic       brake_n = 1'b1;
    logic       ilim_trip = 1'b0;
    logic       uv_flag = 1'b0;
    logic       pwm_gate = 1'b1;
    logic [2:0] hs_n;
    logic [2:0] ls;
    logic       fault_n;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #2.5 clk = ~clk;

    bldc_gate_drive #(.DEAD_CYC(DEAD), .BLANK_CYC(BLANK)) u_dut (
        .clk(clk), .rst(rst), .phase_idx(phase_idx), .dir_rev(dir_rev),
        .brake_n(brake_n), .ilim_trip(ilim_trip), .uv_flag(uv_flag),
        .pwm_gate(pwm_gate), .hs_n(hs_n), .ls(ls), .fault_n(fault_n)
    );

    // Reference model state.
    bit m_hi [3];
    bit m_lo [3];
    int m_hc [3];
    int m_lc [3];
    int m_blank;
    bit m_fault_n;

    function automatic int hi_phase(input int k);
        return k / 2;
    endfunction

    function automatic int lo_phase(input int k);
        return (k % 2 == 1) ? (k / 2 + 2) % 3 : (k / 2 + 1) % 3;
    endfunction

    always @(posedge clk) begin
        bit rh [3];
        bit rl [3];
        bit nh [3];
        bit nl [3];
        if (rst) begin
            for (int i = 0; i < 3; i++) begin
                m_hi[i] = 0; m_lo[i] = 0; m_hc[i] = DEAD; m_lc[i] = DEAD;
            end
            m_blank = 0;
            m_fault_n = 1;
        end else begin
            for (int i = 0; i < 3; i++) begin rh[i] = 0; rl[i] = 0; end
            if (uv_flag) begin
            end else if (!brake_n) begin
                for (int i = 0; i < 3; i++) rl[i] = 1;
            end else if (phase_idx < 6) begin
                int k;
                k = dir_rev ? 5 - int'(phase_idx) : int'(phase_idx);
                rh[hi_phase(k)] = 1;
                if (m_blank == 0 && pwm_gate) rl[lo_phase(k)] = 1;
            end
            for (int i = 0; i < 3; i++) begin
                nh[i] = rh[i] && !rl[i] && (m_hi[i] || (!m_lo[i] && m_lc[i] >= DEAD - 1));
                nl[i] = rl[i] && !rh[i] && (m_lo[i] || (!m_hi[i] && m_hc[i] >= DEAD - 1));
            end
            for (int i = 0; i < 3; i++) begin
                m_hc[i] = m_hi[i] ? 0 : (m_hc[i] >= DEAD ? DEAD : m_hc[i] + 1);
                m_lc[i] = m_lo[i] ? 0 : (m_lc[i] >= DEAD ? DEAD : m_lc[i] + 1);
                m_hi[i] = nh[i];
                m_lo[i] = nl[i];
            end
            if (ilim_trip) m_blank = BLANK;
            else if (m_blank > 0) m_blank = m_blank - 1;
            m_fault_n = !uv_flag;
        end
    end

    function automatic logic [2:0] exp_hs_n();
        return ~{m_hi[2], m_hi[1], m_hi[0]};
    endfunction

    function automatic logic [2:0] exp_ls();
        return {m_lo[2], m_lo[1], m_lo[0]};
    endfunction

    task automatic check3(input string tag, input logic [2:0] act, input logic [2:0] exp, input string what);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %b expected %b at %0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic check_model(input string tag);
        check3(tag, hs_n, exp_hs_n(), "hs_n");
        check3(tag, ls, exp_ls(), "ls");
        check3(tag, {2'b00, fault_n}, {2'b00, m_fault_n}, "fault_n");
        n_tests++;
        if ((~hs_n & ls) != 3'b000) begin
            n_fail++;
            $display("FAIL R9 leg overlap: actual hs_n=%b ls=%b expected no shared leg", hs_n, ls);
        end
    endtask

    // Advance one edge and sample 1 ns later.
    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    string tag;

    initial begin
        int hold;
        rst = 1'b1;
        repeat (3) tick();
        check3("R1", hs_n, 3'b111, "reset hs_n");
        check3("R1", ls, 3'b000, "reset ls");
        check3("R1", {2'b00, fault_n}, 3'b001, "reset fault_n");
        rst = 1'b0;

        // R2: forward step 0 settles to A high, B low.
        phase_idx = 3'd0; dir_rev = 0; pwm_gate = 1;
        tick(); check_model("R2");
        repeat (DEAD + 1) tick();
        check3("R2", hs_n, 3'b110, "step0 hs_n");
        check3("R2", ls, 3'b010, "step0 ls");

        // R5: PWM off keeps the high side, drops the low side.
        pwm_gate = 0; tick();
        check3("R5", hs_n, 3'b110, "pwm off hs_n");
        check3("R5", ls, 3'b000, "pwm off ls");
        pwm_gate = 1; tick();
        check3("R5", ls, 3'b010, "pwm on ls");

        // R10: step 3 swaps legs A and B; both off for DEAD cycles.
        phase_idx = 3'd3;
        begin
            int off_cnt;
            off_cnt = 0;
            for (int c = 0; c < DEAD + 4; c++) begin
                tick();
                if (hs_n == 3'b111 && ls == 3'b000) off_cnt++;
            end
            check3("R10", 3'(off_cnt), 3'(DEAD), "dead cycles");
            check3("R10", hs_n, 3'b101, "step3 hs_n");
            check3("R10", ls, 3'b001, "step3 ls");
        end

        // R3: reverse step 2 equals forward step 3.
        dir_rev = 1; phase_idx = 3'd2;
        repeat (DEAD + 3) tick();
        check3("R3", hs_n, 3'b101, "rev step2 hs_n");
        check3("R3", ls, 3'b001, "rev step2 ls");

        // R7: one trip pulse blanks the low side for BLANK cycles.
        ilim_trip = 1; tick(); ilim_trip = 0;
        check3("R7", ls, 3'b001, "edge of trip");
        begin
            int blank_cnt;
            blank_cnt = 0;
            for (int c = 0; c < BLANK + 3; c++) begin
                tick();
                if (ls == 3'b000) blank_cnt++;
            end
            check3("R7", 3'(blank_cnt), 3'(BLANK), "blank cycles");
        end

        // R4: invalid steps.
        phase_idx = 3'd7; tick();
        check3("R4", hs_n, 3'b111, "idx7 hs_n");
        check3("R4", ls, 3'b000, "idx7 ls");

        // R6: brake with a trip still pending.
        ilim_trip = 1; brake_n = 0; tick(); ilim_trip = 0;
        repeat (DEAD + 1) tick();
        check3("R6", hs_n, 3'b111, "brake hs_n");
        check3("R6", ls, 3'b111, "brake ls");

        // R8: undervoltage beats brake.
        uv_flag = 1; tick();
        check3("R8", hs_n, 3'b111, "uv hs_n");
        check3("R8", ls, 3'b000, "uv ls");
        check3("R8", {2'b00, fault_n}, 3'b000, "uv fault_n");
        uv_flag = 0; brake_n = 1; phase_idx = 3'd1; dir_rev = 0;
        tick(); check_model("R8");

        // Random phase with model comparison.
        void'($urandom(32'd4426));
        hold = 0;
        for (int c = 0; c < 4000; c++) begin
            if (hold == 0) begin
                phase_idx = 3'($urandom_range(0, 7));
                if ($urandom_range(0, 9) == 0) dir_rev = ~dir_rev;
                hold = $urandom_range(1, 12);
            end else begin
                hold--;
            end
            pwm_gate  = ($urandom_range(0, 3) != 0);
            ilim_trip = ($urandom_range(0, 24) == 0);
            if ($urandom_range(0, 60) == 0) brake_n = ~brake_n;
            uv_flag   = ($urandom_range(0, 80) == 0);
            if (uv_flag) tag = "R8";
            else if (!brake_n) tag = "R6";
            else if (m_blank != 0) tag = "R7";
            else if (phase_idx > 5) tag = "R4";
            else if (!pwm_gate) tag = "R5";
            else if (dir_rev) tag = "R3";
            else tag = "R2";
            tick();
            check_model(tag);
        end

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #200000;
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule